// File: doc/BRIEF.md
# UART Receive Path with Per-Character Line Status

This block is the receive half of a UART channel. It oversamples the serial line at sixteen times the bit rate, frames each character (start bit, eight data bits sent least significant bit first, an optional parity bit, one stop bit), and checks parity and stop-bit validity. Every accepted character is stored together with its own parity-error and framing-error tags. Storage is either a 16-entry FIFO or a single holding register, depending on a mode input.

A host reads two registers through a read strobe and a 3-bit address. Offset 0 returns the oldest stored character and removes it. Offset 5 returns the line status byte. Reading the status byte clears the overrun flag and the error tags of the character at the head. Each error tag appears in the status byte only while its own character is at the head of storage. When the FIFO is full, a further character is discarded and flagged as an overrun. In single-register mode, a further character replaces the unread one instead.

Top module: `uart_rx_status`

## Requirements
- R1: After synchronous reset, a read at offset 5 returns 0x00, and a read at offset 0 with nothing stored returns 0x00.
- R2: The status byte at offset 5 holds data-ready in bit 0, overrun in bit 1, parity error in bit 2 and framing error in bit 3, with bits 7..4 zero. A read at offset 0 returns the head character and removes it. Read data appears on `rd_data` the cycle after the strobe.
- R3: A character whose stop-bit mid-sample is 0 is stored with its framing-error tag set.
- R4: With `parity_en`=1, a parity bit follows the data. A mismatch sets the character's parity-error tag: when `parity_even`=1 the nine bits must hold an even number of ones, and when it is 0 an odd number. With `parity_en`=0 no parity bit is expected.
- R5: A status read clears the parity and framing tags of the current head character. A following status read shows both bits as 0.
- R6: In FIFO mode, a character's error tags show in the status byte only while that character is at the head. Errors on later entries stay hidden until then.
- R7: After a framing error, the low stop bit is taken as the start bit of the next character. The receiver confirms it once more and then shifts in that character's data, so the second character is received intact.
- R8: With `fifo_en`=1, 16 characters are held. A character that completes while all 16 are held is discarded and sets overrun. The held characters stay intact and in order.
- R9: With `fifo_en`=0, a character that completes while the holding register is unread replaces it (data and tags) and sets overrun.
- R10: Overrun stays set through data reads and clears only on a status read.
- R11: Data-ready stays 1 while any character is stored and becomes 0 only after the last one is read.
- R12: If a status read and a new overrun fall in the same cycle, overrun ends that cycle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | Enable pulse at 16x the bit rate |
| rx_in | input | 1 | Serial receive line, idle high |
| fifo_en | input | 1 | 1: 16-entry FIFO, 0: single holding register |
| parity_en | input | 1 | 1: a parity bit follows the data bits |
| parity_even | input | 1 | 1: even parity, 0: odd parity |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 3 | Register offset (0 data, 5 status) |
| rd_data | output | 8 | Registered read data |

## Verification
The bench sends a character whose low stop bit is the start of the next one. A receiver that did not resynchronise would lose the second character or shift its bits. It places a parity-bad character behind a clean one, which catches tags raised early or attached to the wrong entry. It fills the FIFO and sends one more character, which catches a design that overwrites stored data or never flags overrun. It also holds the status read active across the instant the overrun occurs, where a design that lets the clear win would never show the flag.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W = 8;
    localparam int OVS    = 16;
    localparam int MID    = OVS / 2 - 1;

    localparam logic [2:0] ADDR_DATA   = 3'd0;
    localparam logic [2:0] ADDR_STATUS = 3'd5;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_char_t;

    typedef struct packed {
        logic fe;
        logic pe;
        logic oe;
        logic dr;
    } line_stat_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                        input logic p,
                                        input logic even);
        return (^{d, p}) ^ ~even;
    endfunction

endpackage

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter
    import uart_rx_pkg::*;
#(
    parameter int OVSR = OVS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sample_tick,
    input  logic     rx_in,
    input  logic     parity_en,
    input  logic     parity_even,
    output logic     char_valid,
    output rx_char_t char_out
);
    localparam int CW  = $clog2(OVSR);
    localparam int BW  = $clog2(DATA_W);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVSR - 1);
    localparam logic [CW-1:0] CNT_CHK  = CW'(OVSR / 2 - 2);
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

    rx_state_e         st;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    logic [1:0]        sync_q;
    logic              rxs;

    assign rxs = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q     <= 2'b11;
            st         <= RX_IDLE;
            cnt        <= '0;
            bitn       <= '0;
            shreg      <= '0;
            par_q      <= 1'b0;
            char_valid <= 1'b0;
            char_out   <= '0;
        end else begin
            sync_q     <= {sync_q[0], rx_in};
            char_valid <= 1'b0;
            if (sample_tick) begin
                unique case (st)
                    RX_IDLE: begin
                        if (!rxs) begin
                            st  <= RX_START;
                            cnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CNT_CHK) begin
                            cnt  <= '0;
                            bitn <= '0;
                            st   <= rxs ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == CNT_LAST) begin
                            cnt   <= '0;
                            shreg <= {rxs, shreg[DATA_W-1:1]};
                            if (bitn == BIT_LAST) begin
                                st <= parity_en ? RX_PAR : RX_STOP;
                            end else begin
                                bitn <= bitn + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (cnt == CNT_LAST) begin
                            cnt   <= '0;
                            par_q <= rxs;
                            st    <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == CNT_LAST) begin
                            char_valid    <= 1'b1;
                            char_out.data <= shreg;
                            char_out.perr <= parity_en & parity_bad(shreg, par_q, parity_even);
                            char_out.ferr <= ~rxs;
                            if (rxs) begin
                                st  <= RX_IDLE;
                                cnt <= '0;
                            end else begin
                                // low stop bit is taken as the next start bit
                                st  <= RX_START;
                                cnt <= CNT_CHK;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        char_valid |=> !char_valid);

    // R7
    resync_chk: assert property (@(posedge clk) disable iff (rst)
        (char_valid && char_out.ferr) |-> (st == RX_START));

endmodule

// File: rtl/rx_char_store.sv
module rx_char_store
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fifo_en,
    input  logic                     wr_en,
    input  rx_char_t                 wr_char,
    input  logic                     pop,
    input  logic                     clr_err,
    output rx_char_t                 head,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    rx_char_t       mem [DEPTH];
    logic [AW-1:0]  rd_ptr, wr_ptr;
    logic           have, pop_ok, accept, replace;
    logic [CW-1:0]  after_pop, cap;

    always_comb begin
        have      = (count != '0);
        pop_ok    = pop && have;
        after_pop = count - CW'(pop_ok);
        cap       = fifo_en ? CW'(DEPTH) : CW'(1);
        accept    = wr_en && (after_pop < cap);
        replace   = wr_en && !accept && !fifo_en;
        overrun   = wr_en && !accept;
        head      = have ? mem[rd_ptr] : '0;
    end

    always_ff @(posedge clk) begin
        if (clr_err && have) begin
            mem[rd_ptr].perr <= 1'b0;
            mem[rd_ptr].ferr <= 1'b0;
        end
        if (accept) begin
            mem[wr_ptr] <= wr_char;
        end else if (replace) begin
            mem[rd_ptr] <= wr_char;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            if (accept)  wr_ptr <= wr_ptr + 1'b1;
            count <= after_pop + CW'(accept);
        end
    end

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && wr_en && !pop && count == CW'(DEPTH)) |=> (count == CW'(DEPTH)));

    // R9
    replace_keeps_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && wr_en && !pop && count == CW'(1)) |=> (count == CW'(1)));

    // R11
    last_read_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(1) && pop && !wr_en) |=> (count == '0));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_tick,
    input  logic       rx_in,
    input  logic       fifo_en,
    input  logic       parity_en,
    input  logic       parity_even,
    input  logic       rd_en,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    logic           char_valid;
    rx_char_t       new_char;
    rx_char_t       head;
    logic [CW-1:0]  count;
    logic           overrun;
    logic           oe_q;
    logic           rd_dat, rd_stat;
    line_stat_t     stat;

    uart_rx_shifter #(.OVSR(OVS)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .sample_tick (sample_tick),
        .rx_in       (rx_in),
        .parity_en   (parity_en),
        .parity_even (parity_even),
        .char_valid  (char_valid),
        .char_out    (new_char)
    );

    rx_char_store #(.DEPTH(FIFO_DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .fifo_en (fifo_en),
        .wr_en   (char_valid),
        .wr_char (new_char),
        .pop     (rd_dat),
        .clr_err (rd_stat),
        .head    (head),
        .count   (count),
        .overrun (overrun)
    );

    always_comb begin
        rd_dat  = rd_en && (rd_addr == ADDR_DATA);
        rd_stat = rd_en && (rd_addr == ADDR_STATUS);
        stat.dr = (count != '0);
        stat.oe = oe_q;
        stat.pe = head.perr;
        stat.fe = head.ferr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q    <= 1'b0;
            rd_data <= '0;
        end else begin
            if (overrun)      oe_q <= 1'b1;
            else if (rd_stat) oe_q <= 1'b0;
            if (rd_dat)       rd_data <= head.data;
            else if (rd_stat) rd_data <= {4'b0000, stat};
            else              rd_data <= '0;
        end
    end

    // R12
    overrun_wins_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> oe_q);

    // R10
    oe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_q && !rd_stat) |=> oe_q);

    // R10
    oe_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !overrun) |=> !oe_q);

    // R2
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rd_stat) |-> (rd_data[7:4] == 4'b0000));

endmodule

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_tick = 1'b1;
    logic       rx_in = 1'b1;
    logic       fifo_en = 1'b0;
    logic       parity_en = 1'b0;
    logic       parity_even = 1'b1;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] d;
        bit         pe;
        bit         fe;
    } mchar_t;

    mchar_t m_q[$];
    bit     m_oe = 0;

    always #10 clk = ~clk;

    uart_rx_status dut (
        .clk(clk), .rst(rst), .sample_tick(sample_tick), .rx_in(rx_in),
        .fifo_en(fifo_en), .parity_en(parity_en), .parity_even(parity_even),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=0x%02h exp=0x%02h", tag, got, exp);
        end
    endtask

    function automatic void m_push(input logic [7:0] d, input bit pe, input bit fe);
        mchar_t c;
        c.d = d; c.pe = pe; c.fe = fe;
        if (fifo_en) begin
            if (m_q.size() < 16) m_q.push_back(c);
            else m_oe = 1;
        end else begin
            if (m_q.size() == 1) begin m_q[0] = c; m_oe = 1; end
            else m_q.push_back(c);
        end
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_q.delete();
        m_oe = 0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic read_status(input string tag);
        logic [7:0] v, e;
        bus_read(3'd5, v);
        e = 8'h00;
        if (m_q.size() > 0) begin
            e[0] = 1'b1;
            e[2] = m_q[0].pe;
            e[3] = m_q[0].fe;
            m_q[0].pe = 0;
            m_q[0].fe = 0;
        end
        e[1] = m_oe;
        m_oe = 0;
        check(tag, v, e);
    endtask

    task automatic read_data(input string tag);
        logic [7:0] v, e;
        bus_read(3'd0, v);
        e = 8'h00;
        if (m_q.size() > 0) e = m_q.pop_front().d;
        check(tag, v, e);
    endtask

    task automatic drive_slot(input logic b);
        rx_in = b;
        repeat (16) @(negedge clk);
    endtask

    // with_start=0 continues a character whose start is the previous low slot
    task automatic send_bits(input logic [7:0] d, input bit pbad, input bit with_start,
                             input bit stop_low);
        logic p;
        if (with_start) drive_slot(1'b0);
        for (int i = 0; i < 8; i++) drive_slot(d[i]);
        if (parity_en) begin
            p = parity_even ? ^d : ~^d;
            drive_slot(p ^ pbad);
        end
        drive_slot(~stop_low);
        if (!stop_low) begin
            rx_in = 1'b1;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic send_char(input logic [7:0] d, input bit pbad);
        send_bits(d, pbad, 1'b1, 1'b0);
        m_push(d, pbad & parity_en, 1'b0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit seen_oe;
        do_reset();

        // R1 reset state
        read_status("R1 status after reset");
        read_data("R1 data read when empty");

        // R2 basic, single register, no parity
        send_char(8'hA5, 0);
        read_status("R2 status with one char");
        read_data("R2 data of head char");
        read_status("R11 data ready clear after last read");

        // R4 even and odd parity
        parity_en = 1; parity_even = 1;
        send_char(8'h3C, 0);
        read_status("R4 even parity good");
        read_data("R4 even data");
        send_char(8'h3D, 1);
        read_status("R4 even parity bad");
        read_status("R5 parity cleared by status read");
        read_data("R4 data of bad char");
        parity_even = 0;
        send_char(8'h81, 0);
        read_status("R4 odd parity good");
        read_data("R4 odd data");
        send_char(8'h81, 1);
        read_status("R4 odd parity bad");
        read_data("R4 odd bad data");

        // R9 overwrite replaces data and tags
        send_char(8'h11, 1);
        send_char(8'h22, 0);
        read_status("R9 overwrite sets overrun, tags replaced");
        read_data("R9 overwritten data");
        parity_en = 0;

        // R10 overrun survives a data read
        send_char(8'h33, 0);
        send_char(8'h44, 0);
        read_data("R10 data read before status");
        read_status("R10 overrun still set");
        read_status("R10 overrun cleared by status read");

        // R3 / R7 framing error followed by resynchronised char
        do_reset();
        fifo_en = 1;
        send_bits(8'h5A, 0, 1'b1, 1'b1);
        send_bits(8'hC3, 0, 1'b0, 1'b0);
        m_push(8'h5A, 0, 1);
        m_push(8'hC3, 0, 0);
        read_status("R3 framing error on head");
        read_data("R3 data of framed char");
        read_status("R7 resync char clean");
        read_data("R7 resync char data");

        // R6 per-character tags in FIFO
        parity_en = 1; parity_even = 1;
        send_char(8'h01, 0);
        send_char(8'h02, 1);
        send_char(8'h03, 0);
        read_status("R6 error hidden behind clean head");
        read_data("R6 first char");
        read_status("R6 error shown at head");
        read_status("R5 error cleared for head");
        read_data("R6 second char");
        read_data("R6 third char");
        read_status("R11 empty after all reads");
        parity_en = 0;

        // R8 FIFO full and overrun drop
        do_reset();
        fifo_en = 1;
        for (int i = 0; i < 17; i++) send_char(8'(i * 7 + 1), 0);
        read_status("R8 overrun after 17th char");
        for (int i = 0; i < 15; i++) read_data("R8 ordered data");
        read_status("R11 data ready with one left");
        read_data("R8 last stored char");
        read_status("R8 dropped char not stored");

        // R12 status read held during the overrun instant
        for (int i = 0; i < 16; i++) send_char(8'(8'hF0 - i), 0);
        seen_oe = 0;
        @(negedge clk);
        rd_en = 1; rd_addr = 3'd5;
        fork
            send_bits(8'h77, 0, 1'b1, 1'b0);
            begin
                repeat (200) begin
                    @(negedge clk);
                    if (rd_data[1]) seen_oe = 1;
                end
            end
        join
        rd_en = 0;
        foreach (m_q[i]) begin m_q[i].pe = 0; m_q[i].fe = 0; end
        m_oe = 0;
        check("R12 overrun seen under continuous status reads", 8'(seen_oe), 8'h01);
        read_status("R12 overrun cleared afterwards");
        read_data("R8 head intact after drop");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule